// File: doc/BRIEF.md
# Flash Command and Status Register Front End

This block is the register face of an on-chip flash controller. Software talks to it over a plain 32-bit register bus with byte offsets. The flow is fixed. Software first opens the controller with a key, then sets write enable and loads a target address. From there it either erases the page that holds that address or programs one 32-bit word at it. The block keeps the registers and decodes the command bits. It reports busy, data-ready and error status, and it checks every loaded address against the flash size and a per-page lock map.

The storage behind the registers is a small behavioural array. An erase sets every word of a page to all ones. A program ANDs the new word into the stored one, so it can only clear bits. The lock map arrives on an input bus, one bit per page and 32 pages to a word. A direct word read port exposes the array contents.

Top module: `flash_cmd_regs`

## Requirements
- R1: After reset, status (offset 0x01C) reads 0, the key register (0x03C) reads 1 (closed), write control (0x008) and the address buffer (0x010) read 0.
- R2: Writes to write control, address buffer, write data (0x018) and write command (0x00C) are ignored while the key is closed. Writing 0x1B71 to 0x03C opens the key and the key register then reads 0. Any other value closes it again.
- R3: Write-command bit 0 copies the address buffer into the loaded address. Status bit 2 (bad address) is then set if the address is at or beyond the flash size or is not a multiple of 4, and cleared otherwise.
- R4: On a load of an in-range address, status bit 1 (page locked) is set when lock bit 32*(page>>5)+(page&31) of the lock input is 0, with page = address / page bytes. Both flags clear on the next clean load.
- R5: With write-control bit 0 set, a clean address loaded and the controller idle, write-command bit 1 holds status bit 0 (busy) for ERASE_CYCLES cycles. Afterwards every word of the addressed page reads 0xFFFFFFFF and other pages are unchanged.
- R6: Write-command bit 3 under the same conditions, with a data word pending, holds busy for PROG_CYCLES cycles. The addressed word then becomes its old value AND the data word.
- R7: Status bit 3 (data ready) is 1 exactly when the controller is idle, a clean address is loaded and no data word is pending. Writing 0x018 makes a word pending, and a completed program consumes it.
- R8: With write-control bit 0 clear, erase and program commands start nothing.
- R9: While the bad-address or page-locked flag is set, erase and program commands start nothing.
- R10: While busy, writes to the address buffer, write data and write command have no effect.
- R11: A program command with no pending data word starts nothing.
- R12: A command word with bit 0 set performs only the address load. Otherwise erase (bit 1) takes precedence over program (bit 3).
- R13: A read returns its data on rd_data with rd_valid high in the cycle after the request. Write data, write command and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ofs | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| lock_words | input | 32*ceil(NUM_PAGES/32) | Page lock map, 0 = locked |
| arr_idx | input | clog2(PAGE_WORDS*NUM_PAGES) | Word index for direct array read |
| arr_data | output | 32 | Array word at arr_idx |

## Verification
The hardest case to reach from the ports is a register access that lands while an operation is in flight. Software following the normal flow always polls busy to zero first, so the ignore-while-busy rule is never tested by the regular flow. The stimulus therefore issues an address-buffer write, an address load and a data write immediately behind an erase command. It then reads back the buffer and the data-ready flag. A second hard case is a page whose lock bit sits in the second lock word. The stimulus clears a chosen bit there directly. A seeded random phase mixes loads of good, misaligned and out-of-range addresses with random command words against a bench model of the array.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   localparam int OFS_W = 8;

   localparam logic [OFS_W-1:0] OFS_WCTRL = 8'h08;
   localparam logic [OFS_W-1:0] OFS_WCMD  = 8'h0C;
   localparam logic [OFS_W-1:0] OFS_ADDRB = 8'h10;
   localparam logic [OFS_W-1:0] OFS_WDATA = 8'h18;
   localparam logic [OFS_W-1:0] OFS_STAT  = 8'h1C;
   localparam logic [OFS_W-1:0] OFS_KEY   = 8'h3C;

   localparam logic [31:0] OPEN_KEY = 32'h0000_1B71;

   // command bit positions
   localparam int CB_LOAD  = 0;
   localparam int CB_ERASE = 1;
   localparam int CB_PROG  = 3;

   // status bit positions
   localparam int SB_BUSY = 0;
   localparam int SB_LOCK = 1;
   localparam int SB_BAD  = 2;
   localparam int SB_RDY  = 3;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_ERASE = 2'd1,
      SQ_PROG  = 2'd2
   } seq_state_e;

endpackage

// File: rtl/fcr_addr_check.sv
module fcr_addr_check #(
   parameter int FLASH_BYTES = 2560,
   parameter int PAGE_BYTES  = 64,
   parameter int LOCK_WORDS  = 2
) (
   input  logic [31:0]              addr,
   input  logic [LOCK_WORDS*32-1:0] lock_words,
   output logic                     bad_addr,
   output logic                     page_locked
);
   localparam int PG_SH = $clog2(PAGE_BYTES);
   localparam int LW_W  = (LOCK_WORDS > 1) ? $clog2(LOCK_WORDS) : 1;

   logic [31:0] sel_word;
   logic [4:0]  bit_sel;

   // page & 31 picks the bit, page >> 5 picks the word
   assign bit_sel = addr[PG_SH +: 5];

   generate
      if (LOCK_WORDS == 1) begin : g_one_word
         assign sel_word = lock_words[31:0];
      end else begin : g_word_mux
         logic [LW_W-1:0] wsel;
         assign wsel     = addr[PG_SH+5 +: LW_W];
         assign sel_word = lock_words[32*wsel +: 32];
      end
   endgenerate

   assign bad_addr    = (addr >= 32'(FLASH_BYTES)) || (addr[1:0] != 2'b00);
   assign page_locked = !bad_addr && !sel_word[bit_sel];

endmodule

// File: rtl/fcr_seq.sv
module fcr_seq
   import flash_cmd_pkg::*;
#(
   parameter int PAGE_WORDS   = 16,
   parameter int IDX_W        = 10,
   parameter int ERASE_CYCLES = 40,
   parameter int PROG_CYCLES  = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_erase,
   input  logic             start_prog,
   input  logic [IDX_W-1:0] start_idx,
   output logic             busy,
   output logic             prog_done,
   output logic             wr_en,
   output logic             wr_erase,
   output logic [IDX_W-1:0] wr_idx
);
   localparam int CNT_W = $clog2(ERASE_CYCLES + PROG_CYCLES + 1);
   localparam int PW_SH = $clog2(PAGE_WORDS);
   localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYCLES - 1);
   localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYCLES - 1);
   localparam logic [CNT_W-1:0] PW_CNT     = CNT_W'(PAGE_WORDS);

   seq_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [IDX_W-1:0] base_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         cnt_q   <= '0;
         base_q  <= '0;
      end else begin
         case (state_q)
            SQ_IDLE: begin
               cnt_q <= '0;
               if (start_erase) begin
                  state_q <= SQ_ERASE;
                  base_q  <= {start_idx[IDX_W-1:PW_SH], PW_SH'(0)};
               end else if (start_prog) begin
                  state_q <= SQ_PROG;
                  base_q  <= start_idx;
               end
            end
            SQ_ERASE: begin
               if (cnt_q == ERASE_LAST) begin
                  state_q <= SQ_IDLE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            SQ_PROG: begin
               if (cnt_q == PROG_LAST) begin
                  state_q <= SQ_IDLE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != SQ_IDLE);
   assign prog_done = (state_q == SQ_PROG) && (cnt_q == PROG_LAST);
   assign wr_erase  = (state_q == SQ_ERASE);
   assign wr_en     = (wr_erase && (cnt_q < PW_CNT)) || prog_done;
   assign wr_idx    = wr_erase ? (base_q | IDX_W'(cnt_q[PW_SH-1:0])) : base_q;

   // R10: a start request only ever reaches an idle sequencer
   assert_start_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (start_erase || start_prog) |-> (state_q == SQ_IDLE));

   // R5: erase counter stays inside its window
   assert_erase_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_ERASE) |-> (cnt_q <= ERASE_LAST));

   // R6: program counter stays inside its window
   assert_prog_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_PROG) |-> (cnt_q <= PROG_LAST));

endmodule

// File: rtl/fcr_array.sv
module fcr_array #(
   parameter int DEPTH = 640,
   parameter int IDX_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_erase,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [31:0]      wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [31:0]      rd_data
);
   logic [31:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[wr_idx] <= wr_erase ? 32'hFFFF_FFFF : (mem[wr_idx] & wr_data);
      end
   end

   assign rd_data = mem[rd_idx];

   // R5: an erase write leaves the word all ones
   assert_erase_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_erase) |=> (mem[$past(wr_idx)] == 32'hFFFF_FFFF));

   // R6: a program write never sets a bit that the data word has clear
   assert_and_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_erase) |=> ((mem[$past(wr_idx)] & ~$past(wr_data)) == 32'h0));

endmodule

// File: rtl/flash_cmd_regs.sv
module flash_cmd_regs
   import flash_cmd_pkg::*;
#(
   parameter int PAGE_WORDS   = 16,
   parameter int NUM_PAGES    = 40,
   parameter int ERASE_CYCLES = 40,
   parameter int PROG_CYCLES  = 6
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   req_valid,
   input  logic                                   req_write,
   input  logic [7:0]                             req_ofs,
   input  logic [31:0]                            req_wdata,
   output logic                                   rd_valid,
   output logic [31:0]                            rd_data,
   input  logic [((NUM_PAGES+31)/32)*32-1:0]      lock_words,
   input  logic [$clog2(PAGE_WORDS*NUM_PAGES)-1:0] arr_idx,
   output logic [31:0]                            arr_data
);
   localparam int DEPTH       = PAGE_WORDS * NUM_PAGES;
   localparam int IDX_W       = $clog2(DEPTH);
   localparam int PAGE_BYTES  = PAGE_WORDS * 4;
   localparam int FLASH_BYTES = DEPTH * 4;
   localparam int LOCK_WORDS  = (NUM_PAGES + 31) / 32;

   generate
      if ((PAGE_WORDS < 2) || ((PAGE_WORDS & (PAGE_WORDS - 1)) != 0)) begin : g_bad_page
         $error("PAGE_WORDS must be a power of two, at least 2");
      end
      if (ERASE_CYCLES < PAGE_WORDS) begin : g_bad_erase
         $error("ERASE_CYCLES must cover one write per page word");
      end
      if (PROG_CYCLES < 1) begin : g_bad_prog
         $error("PROG_CYCLES must be at least 1");
      end
   endgenerate

   // ---------------- registers ----------------
   logic             key_open_q;
   logic             wren_q;
   logic [31:0]      addrb_q;
   logic [IDX_W-1:0] ld_idx_q;
   logic             flag_bad_q;
   logic             flag_lock_q;
   logic             addr_ok_q;
   logic [31:0]      wdata_q;
   logic             pending_q;

   logic             seq_busy, seq_done, arr_we, arr_erase;
   logic [IDX_W-1:0] arr_widx;
   logic             chk_bad, chk_locked;

   // ---------------- decode ----------------
   logic bus_wr, open_gate, reg_gate;
   logic hit_wctrl, hit_wcmd, hit_addrb, hit_wdata, hit_key;
   logic do_load, do_erase, do_prog;

   assign bus_wr    = req_valid && req_write;
   assign hit_wctrl = bus_wr && (req_ofs == OFS_WCTRL);
   assign hit_wcmd  = bus_wr && (req_ofs == OFS_WCMD);
   assign hit_addrb = bus_wr && (req_ofs == OFS_ADDRB);
   assign hit_wdata = bus_wr && (req_ofs == OFS_WDATA);
   assign hit_key   = bus_wr && (req_ofs == OFS_KEY);

   assign open_gate = key_open_q;
   assign reg_gate  = key_open_q && !seq_busy;

   assign do_load  = reg_gate && hit_wcmd && req_wdata[CB_LOAD];
   assign do_erase = reg_gate && hit_wcmd && !req_wdata[CB_LOAD] && req_wdata[CB_ERASE]
                     && wren_q && addr_ok_q;
   assign do_prog  = reg_gate && hit_wcmd && !req_wdata[CB_LOAD] && !req_wdata[CB_ERASE]
                     && req_wdata[CB_PROG] && wren_q && addr_ok_q && pending_q;

   // ---------------- address check ----------------
   fcr_addr_check #(
      .FLASH_BYTES (FLASH_BYTES),
      .PAGE_BYTES  (PAGE_BYTES),
      .LOCK_WORDS  (LOCK_WORDS)
   ) u_check (
      .addr        (addrb_q),
      .lock_words  (lock_words),
      .bad_addr    (chk_bad),
      .page_locked (chk_locked)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_open_q  <= 1'b0;
         wren_q      <= 1'b0;
         addrb_q     <= '0;
         ld_idx_q    <= '0;
         flag_bad_q  <= 1'b0;
         flag_lock_q <= 1'b0;
         addr_ok_q   <= 1'b0;
         wdata_q     <= '0;
         pending_q   <= 1'b0;
      end else begin
         if (hit_key) begin
            key_open_q <= (req_wdata == OPEN_KEY);
         end
         if (open_gate && hit_wctrl) begin
            wren_q <= req_wdata[0];
         end
         if (reg_gate && hit_addrb) begin
            addrb_q <= req_wdata;
         end
         if (do_load) begin
            flag_bad_q  <= chk_bad;
            flag_lock_q <= chk_locked;
            addr_ok_q   <= !chk_bad && !chk_locked;
            ld_idx_q    <= addrb_q[IDX_W+1:2];
         end
         if (reg_gate && hit_wdata) begin
            wdata_q   <= req_wdata;
            pending_q <= 1'b1;
         end else if (seq_done) begin
            pending_q <= 1'b0;
         end
      end
   end

   // ---------------- sequencer and array ----------------
   fcr_seq #(
      .PAGE_WORDS   (PAGE_WORDS),
      .IDX_W        (IDX_W),
      .ERASE_CYCLES (ERASE_CYCLES),
      .PROG_CYCLES  (PROG_CYCLES)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_erase (do_erase),
      .start_prog  (do_prog),
      .start_idx   (ld_idx_q),
      .busy        (seq_busy),
      .prog_done   (seq_done),
      .wr_en       (arr_we),
      .wr_erase    (arr_erase),
      .wr_idx      (arr_widx)
   );

   fcr_array #(
      .DEPTH (DEPTH),
      .IDX_W (IDX_W)
   ) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (arr_we),
      .wr_erase (arr_erase),
      .wr_idx   (arr_widx),
      .wr_data  (wdata_q),
      .rd_idx   (arr_idx),
      .rd_data  (arr_data)
   );

   // ---------------- status and read path ----------------
   logic        data_rdy;
   logic [31:0] status_w;

   assign data_rdy = addr_ok_q && !pending_q && !seq_busy;

   always_comb begin
      status_w          = '0;
      status_w[SB_BUSY] = seq_busy;
      status_w[SB_LOCK] = flag_lock_q;
      status_w[SB_BAD]  = flag_bad_q;
      status_w[SB_RDY]  = data_rdy;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= req_valid && !req_write;
         if (req_valid && !req_write) begin
            case (req_ofs)
               OFS_WCTRL: rd_data <= {31'b0, wren_q};
               OFS_ADDRB: rd_data <= addrb_q;
               OFS_STAT:  rd_data <= status_w;
               OFS_KEY:   rd_data <= {31'b0, !key_open_q};
               default:   rd_data <= '0;
            endcase
         end
      end
   end

   // R2: an operation only starts while the key was open
   assert_key_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seq_busy) |-> $past(key_open_q));

   // R8: an operation only starts with write enable set
   assert_wren_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seq_busy) |-> $past(wren_q));

   // R9: an operation never starts with an address flag raised
   assert_flag_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seq_busy) |-> (!$past(flag_bad_q) && !$past(flag_lock_q)));

   // R7: a finished program leaves the controller ready for the next word
   assert_ready_after_prog_R7: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> data_rdy);

endmodule

// File: tb/flash_cmd_regs_bench.sv
module flash_cmd_regs_bench;
   localparam int PW    = 16;
   localparam int NP    = 40;
   localparam int DEPTH = PW * NP;
   localparam int FB    = DEPTH * 4;
   localparam int EC    = 40;
   localparam int PC    = 6;
   localparam int IW    = $clog2(DEPTH);

   localparam logic [7:0] A_WCTRL = 8'h08, A_WCMD = 8'h0C, A_ADDRB = 8'h10,
                          A_WDATA = 8'h18, A_STAT = 8'h1C, A_KEY = 8'h3C;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [7:0]    req_ofs = '0;
   logic [31:0]   req_wdata = '0;
   logic          rd_valid;
   logic [31:0]   rd_data;
   logic [63:0]   lw_bits = '1;
   logic [IW-1:0] arr_idx = '0;
   logic [31:0]   arr_data;

   always #10 clk = ~clk;

   flash_cmd_regs #(.PAGE_WORDS(PW), .NUM_PAGES(NP), .ERASE_CYCLES(EC), .PROG_CYCLES(PC))
   u_flash_cmd_regs (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_ofs(req_ofs), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
      .lock_words(lw_bits), .arr_idx(arr_idx), .arr_data(arr_data)
   );

   int  n_chk = 0, n_bad = 0;
   bit  finished = 1'b0;

   // bench model
   logic [31:0] bm [DEPTH];
   logic        m_wren = 0, m_ok = 0, m_bad = 0, m_lk = 0, m_pend = 0;
   logic [31:0] m_addrb = 0, m_wd = 0;
   int          m_idx = 0;

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %08h expected %08h", tag, got, exp);
      end
   endtask

   function automatic bit f_bad(logic [31:0] a);
      return (a >= 32'(FB)) || (a[1:0] != 2'b00);
   endfunction

   function automatic bit f_lkd(logic [31:0] a);
      int pg;
      if (f_bad(a)) return 1'b0;
      pg = int'(a / 32'(PW * 4));
      return lw_bits[32 * (pg >> 5) + (pg & 31)] == 1'b0;
   endfunction

   function automatic logic [31:0] f_stat(bit busy);
      return {28'b0, m_ok && !m_pend && !busy, m_bad, m_lk, busy};
   endfunction

   task automatic bw(logic [7:0] ofs, logic [31:0] d);
      @(negedge clk);
      req_valid = 1; req_write = 1; req_ofs = ofs; req_wdata = d;
      @(posedge clk); #1;
      req_valid = 0; req_write = 0;
   endtask

   task automatic br(logic [7:0] ofs, output logic [31:0] d);
      @(negedge clk);
      req_valid = 1; req_write = 0; req_ofs = ofs;
      @(posedge clk); #1;
      req_valid = 0;
      d = rd_data;
   endtask

   task automatic cnt_busy(output int n);
      logic [31:0] s;
      n = 0;
      for (int k = 0; k < 200; k++) begin
         br(A_STAT, s);
         if (s[0]) n++;
         else break;
      end
   endtask

   task automatic op_wren(logic b);
      bw(A_WCTRL, {31'b0, b}); m_wren = b;
   endtask

   task automatic op_data(logic [31:0] v);
      bw(A_WDATA, v); m_wd = v; m_pend = 1;
   endtask

   // issue a command, update the model, return the measured busy length
   task automatic op_cmd(logic [31:0] v, output int nb, output int exp_nb);
      exp_nb = 0;
      bw(A_WCMD, v);
      if (v[0]) begin
         m_bad = f_bad(m_addrb);
         m_lk  = f_lkd(m_addrb);
         m_ok  = !m_bad && !m_lk;
         m_idx = int'(m_addrb[IW+1:2]);
      end else if (v[1]) begin
         if (m_wren && m_ok) begin
            for (int i = 0; i < PW; i++) bm[(m_idx / PW) * PW + i] = '1;
            exp_nb = EC;
         end
      end else if (v[3]) begin
         if (m_wren && m_ok && m_pend) begin
            bm[m_idx] = bm[m_idx] & m_wd;
            m_pend = 0;
            exp_nb = PC;
         end
      end
      cnt_busy(nb);
   endtask

   task automatic op_load(logic [31:0] a);
      int nb, en;
      bw(A_ADDRB, a); m_addrb = a;
      op_cmd(32'h1, nb, en);
   endtask

   task automatic chk_stat(string tag);
      logic [31:0] s;
      br(A_STAT, s);
      chk(tag, s, f_stat(1'b0));
   endtask

   task automatic chk_word(string tag, int idx);
      arr_idx = IW'(idx); #1;
      chk(tag, arr_data, bm[idx]);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int nb, en;
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R1: reset state
      br(A_STAT, d);  chk("R1 status", d, 32'h0);
      br(A_KEY, d);   chk("R1 key", d, 32'h1);
      br(A_WCTRL, d); chk("R1 wctrl", d, 32'h0);
      br(A_ADDRB, d); chk("R1 addrb", d, 32'h0);
      // R13: read timing and zero reads
      chk("R13 rd_valid after read", {31'b0, rd_valid}, 32'h1);
      bw(A_WCTRL, 32'h1);
      chk("R13 rd_valid after write", {31'b0, rd_valid}, 32'h0);
      br(8'h20, d);   chk("R13 unmapped", d, 32'h0);

      // R2: key gating
      br(A_WCTRL, d); chk("R2 wctrl ignored while closed", d, 32'h0);
      bw(A_ADDRB, 32'h40);
      br(A_ADDRB, d); chk("R2 addrb ignored while closed", d, 32'h0);
      bw(A_KEY, 32'h1B71);
      br(A_KEY, d);   chk("R2 key open", d, 32'h0);
      op_wren(1);
      br(A_WCTRL, d); chk("R2 wctrl after open", d, 32'h1);
      bw(A_KEY, 32'h0);
      br(A_KEY, d);   chk("R2 key closed again", d, 32'h1);
      bw(A_WCTRL, 32'h0);
      br(A_WCTRL, d); chk("R2 wctrl held while closed", d, 32'h1);
      bw(A_KEY, 32'h1B71);

      // erase the whole array with nothing locked
      for (int p = 0; p < NP; p++) begin
         op_load(32'(p * PW * 4));
         op_cmd(32'h2, nb, en);
      end
      chk("R5 full erase word", {31'b0, bm[DEPTH-1] == '1}, 32'h1);
      chk_word("R5 last word erased", DEPTH - 1);

      // lock map: page 33 locked (word 1 bit 1), page 0 and 1 open
      lw_bits[31:0]  = $urandom | $urandom | 32'h3;
      lw_bits[63:32] = ($urandom | $urandom) & ~32'h2;

      // R3 / R4: address checks
      op_load(32'(FB));       chk_stat("R3 at flash size");
      op_load(32'(FB - 4));   chk_stat("R3 last word");
      op_load(32'h6);         chk_stat("R3 misaligned");
      op_load(32'(33 * 64));  chk_stat("R4 page 33 locked");
      br(A_STAT, d);          chk("R4 locked bit", d & 32'h6, 32'h2);
      op_load(32'h0);         chk_stat("R4 flags clear");
      br(A_STAT, d);          chk("R7 ready after load", d, 32'h8);

      // R6 / R7: program
      op_data(32'h1234_5678);
      br(A_STAT, d);          chk("R7 ready drops on data", d & 32'h8, 32'h0);
      op_cmd(32'h8, nb, en);  chk("R6 program busy", 32'(nb), 32'(PC));
      chk_word("R6 program word", 0);
      chk_stat("R7 ready after program");
      op_data(32'hFF00_FF00);
      op_cmd(32'h8, nb, en);  chk_word("R6 AND result", 0);
      op_load(32'h40);
      op_data(32'h0000_FFFF);
      op_cmd(32'h8, nb, en);  chk_word("R6 page 1 word", PW);

      // R5: erase page 0 leaves page 1 alone
      op_load(32'h4);
      op_cmd(32'h2, nb, en);  chk("R5 erase busy", 32'(nb), 32'(EC));
      chk_word("R5 page 0 erased", 0);
      chk_word("R5 page 1 kept", PW);

      // R10: accesses during busy are ignored
      op_load(32'h40);
      bw(A_WCMD, 32'h2);
      for (int i = 0; i < PW; i++) bm[PW + i] = '1;
      bw(A_ADDRB, 32'h80);
      bw(A_WCMD, 32'h1);
      bw(A_WDATA, 32'h0);
      cnt_busy(nb);
      br(A_ADDRB, d);         chk("R10 addrb kept", d, 32'h40);
      chk_stat("R10 no pending data");
      chk_word("R10 page 1 erased", PW);

      // R8: write enable off
      op_wren(0);
      op_data(32'h0);
      op_cmd(32'h8, nb, en);  chk("R8 program blocked", 32'(nb), 32'h0);
      op_cmd(32'h2, nb, en);  chk("R8 erase blocked", 32'(nb), 32'h0);
      chk_word("R8 word kept", PW);
      op_wren(1);
      op_cmd(32'h8, nb, en);  chk("R8 program after enable", 32'(nb), 32'(PC));
      chk_word("R8 word programmed", PW);

      // R9: flags block operations
      op_load(32'(33 * 64));
      op_data(32'h0);
      op_cmd(32'h8, nb, en);  chk("R9 locked program", 32'(nb), 32'h0);
      op_cmd(32'h2, nb, en);  chk("R9 locked erase", 32'(nb), 32'h0);
      op_load(32'(FB + 64));
      op_cmd(32'h2, nb, en);  chk("R9 bad erase", 32'(nb), 32'h0);

      // R11: program without data
      op_load(32'h8);
      op_data(32'hAAAA_AAAA);
      op_cmd(32'h8, nb, en);
      op_cmd(32'h8, nb, en);  chk("R11 no data program", 32'(nb), 32'h0);
      chk_word("R11 word", 2);

      // R12: load wins over erase and program; erase wins over program
      op_load(32'h0);
      bw(A_ADDRB, 32'hC); m_addrb = 32'hC;
      op_data(32'h0);
      op_cmd(32'hB, nb, en);  chk("R12 load only", 32'(nb), 32'h0);
      chk_stat("R12 status");
      op_cmd(32'hA, nb, en);  chk("R12 erase first", 32'(nb), 32'(EC));
      chk_word("R12 word erased", 3);

      // random phase
      for (int it = 0; it < 250; it++) begin
         int op, r;
         logic [31:0] a;
         op = int'($urandom % 10);
         if (op < 3) begin
            r = int'($urandom % 10);
            if (r < 7)      a = 32'(($urandom % DEPTH) * 4);
            else if (r == 7) a = 32'(FB) + 32'(($urandom % 64) * 4);
            else if (r == 8) a = 32'(($urandom % DEPTH) * 4 + 1 + $urandom % 3);
            else             a = $urandom;
            op_load(a);
            chk_stat("R3 random load");
         end else if (op < 5) begin
            op_data($urandom);
            chk_stat("R7 random data");
         end else if (op < 8) begin
            op_cmd($urandom & 32'h8, nb, en);
            chk("R6 random program busy", 32'(nb), 32'(en));
         end else if (op == 8) begin
            op_cmd($urandom & 32'hE, nb, en);
            chk("R5 random command busy", 32'(nb), 32'(en));
         end else begin
            op_wren(($urandom % 4) != 0);
         end
         if (m_ok) chk_word("R6 random word", m_idx);
      end

      for (int i = 0; i < DEPTH; i++) chk_word("R5 final sweep", i);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule